// File: doc/BRIEF.md
# Eight-Bit Accumulator Processor Core

This block is a small multi-cycle processor built around an 8-bit accumulator. It decodes sixteen one-byte operations covering memory transfers, register copies, arithmetic and logic, and branches. It addresses a flat 64K-byte space through a single memory port with separate read and write strobes. Peripherals are mapped into that same space, so loads and stores reach them too. The port expects read data to be valid in the same cycle as the address.

Each instruction starts with a fetch cycle. Instructions that carry an address then read two more bytes from the code stream, low byte first. A final execute cycle completes the instruction. One-byte instructions therefore take two cycles and three-byte instructions take four. The visible state consists of the accumulator, a second operand register, a one-bit zero flag and a 16-bit program counter. There is no halt instruction: a program ends by jumping to its own address.

Top module: `acc_core`

## Requirements
- R1: On synchronous reset the program counter is 0x0000. The first cycle after reset is a read at address 0x0000 with the write strobe low.
- R2: Opcode 0x01 loads the accumulator from the byte at the 16-bit address that follows the opcode (low byte first). Opcode 0x02 writes the accumulator to that address.
- R3: Opcode 0x03 copies the accumulator into the operand register. Opcode 0x04 copies the operand register into the accumulator.
- R4: Opcode 0x08 adds the operand register to the accumulator and opcode 0x09 subtracts it. Both wrap modulo 256 and set the zero flag exactly when the 8-bit result is zero.
- R5: The following opcodes write the accumulator and set the zero flag exactly when the result is zero: 0x0A (increment, wrapping 0xFF to 0x00), 0x0C (AND with the operand register), 0x0D (OR), 0x0E (XOR) and 0x0F (bitwise invert).
- R6: Opcode 0x0B clears the accumulator and forces the zero flag to 1.
- R7: Opcodes 0x00 to 0x07 leave the zero flag unchanged.
- R8: Opcode 0x05 always loads the program counter with the 16-bit address that follows it.
- R9: Opcode 0x06 branches only when the zero flag is 1, and opcode 0x07 branches only when it is 0. A branch that is not taken continues at the byte after its three-byte instruction.
- R10: Any opcode byte from 0x10 to 0xFF is a one-byte instruction with no effect on state or memory.
- R11: A program summing 1 to n with n = 22, holding its counter and sum in memory, stores 253 as the final sum and produces every intermediate store in order.
- R12: The read and write strobes are never high in the same cycle. A write happens only in the execute cycle of opcode 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Byte address for the current access |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| mem_wdata | output | 8 | Write data (accumulator value) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
The bench targets the zero flag across instructions that must not touch it. A core that let loads or copies rewrite the flag would send a later conditional branch the wrong way, and an unexpected store would follow. Arithmetic wrap is tested with an addition that overflows and a subtraction that borrows, and an increment from 0xFF checks that a zero result raises the flag. A core that kept a ninth bit would store the wrong byte in these cases. Undefined opcodes are placed directly before a single-byte increment, so a core that treated them as address-carrying would swallow that increment. Both conditional branches are tested taken and not taken, and each wrong path is guarded by a store to a forbidden address.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int DW  = 8;
    localparam int AW  = 2 * DW;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_NOP  = 4'h0, OP_LDAC = 4'h1, OP_STAC = 4'h2, OP_MVAC = 4'h3,
        OP_MOVR = 4'h4, OP_JUMP = 4'h5, OP_JMPZ = 4'h6, OP_JPNZ = 4'h7,
        OP_ADD  = 4'h8, OP_SUB  = 4'h9, OP_INAC = 4'hA, OP_CLAC = 4'hB,
        OP_AND  = 4'hC, OP_OR   = 4'hD, OP_XOR  = 4'hE, OP_NOT  = 4'hF
    } op_e;

    typedef enum logic [1:0] {
        ST_FETCH, ST_ADLO, ST_ADHI, ST_EXEC
    } st_e;

    typedef struct packed {
        logic [DW-1:0] val;
        logic          wr_ac;
        logic          wr_z;
    } alu_res_t;

    function automatic op_e decode_op(input logic [DW-1:0] b);
        if (b[DW-1:OPW] != '0) return OP_NOP;
        return op_e'(b[OPW-1:0]);
    endfunction

    function automatic logic needs_addr(input op_e o);
        return (o == OP_LDAC) || (o == OP_STAC) || (o == OP_JUMP) ||
               (o == OP_JMPZ) || (o == OP_JPNZ);
    endfunction

    function automatic logic writes_z(input op_e o);
        return o[OPW-1];
    endfunction
endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] ac,
    input  logic [DW-1:0] r,
    output alu_res_t      res
);
    always_comb begin
        res       = '0;
        res.wr_ac = 1'b1;
        res.wr_z  = 1'b1;
        unique case (op)
            OP_ADD:  res.val = ac + r;
            OP_SUB:  res.val = ac - r;
            OP_INAC: res.val = ac + 1'b1;
            OP_CLAC: res.val = '0;
            OP_AND:  res.val = ac & r;
            OP_OR:   res.val = ac | r;
            OP_XOR:  res.val = ac ^ r;
            OP_NOT:  res.val = ~ac;
            default: begin
                res.wr_ac = 1'b0;
                res.wr_z  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] mem_rdata,
    input  logic          zflag,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          exec,
    output op_e           ir
);
    st_e           state;
    logic [AW-1:0] pc;
    logic [AW-1:0] tgt;
    logic          take;
    op_e           nxt_op;

    assign nxt_op = decode_op(mem_rdata);
    assign exec   = (state == ST_EXEC);
    assign take   = (ir == OP_JUMP) ||
                    ((ir == OP_JMPZ) && zflag) ||
                    ((ir == OP_JPNZ) && !zflag);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
            pc    <= '0;
            tgt   <= '0;
            ir    <= OP_NOP;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir    <= nxt_op;
                    pc    <= pc + 1'b1;
                    state <= needs_addr(nxt_op) ? ST_ADLO : ST_EXEC;
                end
                ST_ADLO: begin
                    tgt[DW-1:0] <= mem_rdata;
                    pc          <= pc + 1'b1;
                    state       <= ST_ADHI;
                end
                ST_ADHI: begin
                    tgt[AW-1:DW] <= mem_rdata;
                    pc           <= pc + 1'b1;
                    state        <= ST_EXEC;
                end
                default: begin
                    if (take) pc <= tgt;
                    state <= ST_FETCH;
                end
            endcase
        end
    end

    always_comb begin
        mem_addr = pc;
        mem_rd   = !exec;
        mem_wr   = 1'b0;
        if (exec && (ir == OP_LDAC)) begin
            mem_addr = tgt;
            mem_rd   = 1'b1;
        end else if (exec && (ir == OP_STAC)) begin
            mem_addr = tgt;
            mem_wr   = 1'b1;
        end
    end

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R12
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        !exec |=> pc == $past(pc) + 1'b1); // R2
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (exec && ir == OP_JUMP) |=> pc == $past(tgt)); // R8
    AST_BRANCH_SKIP: assert property (@(posedge clk) disable iff (rst)
        (exec && ((ir == OP_JMPZ && !zflag) || (ir == OP_JPNZ && zflag)))
        |=> $stable(pc)); // R9
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    output logic [acc_pkg::AW-1:0] mem_addr,
    input  logic [acc_pkg::DW-1:0] mem_rdata,
    output logic [acc_pkg::DW-1:0] mem_wdata,
    output logic                   mem_rd,
    output logic                   mem_wr
);
    logic [DW-1:0] ac;
    logic [DW-1:0] r;
    logic          z;
    logic          exec;
    op_e           ir;
    alu_res_t      alu;

    acc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .zflag     (z),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .exec      (exec),
        .ir        (ir)
    );

    acc_alu u_alu (
        .op  (ir),
        .ac  (ac),
        .r   (r),
        .res (alu)
    );

    assign mem_wdata = ac;

    always_ff @(posedge clk) begin
        if (rst) begin
            ac <= '0;
            r  <= '0;
            z  <= 1'b0;
        end else if (exec) begin
            if (ir == OP_LDAC) ac <= mem_rdata;
            if (ir == OP_MOVR) ac <= r;
            if (ir == OP_MVAC) r  <= ac;
            if (alu.wr_ac)     ac <= alu.val;
            if (alu.wr_z)      z  <= (alu.val == '0);
        end
    end

    AST_CLAC_ZERO: assert property (@(posedge clk) disable iff (rst)
        (exec && ir == OP_CLAC) |=> (z && ac == '0)); // R6
    AST_Z_HOLD: assert property (@(posedge clk) disable iff (rst)
        (exec && !writes_z(ir)) |=> $stable(z)); // R7
    AST_Z_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (exec && writes_z(ir)) |=> (z == (ac == '0))); // R4
endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_rd;
    logic        mem_wr;

    always #2.5 clk = ~clk;

    acc_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    logic [7:0] mem [0:4095];
    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  data;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    int total = 0;
    int bad   = 0;
    int ap;
    logic [15:0] halt_addr;
    int halt_hits;
    logic mon_en = 1'b0;

    task automatic emit(input logic [7:0] b);
        mem[ap[11:0]] = b;
        ap++;
    endtask

    task automatic emit3(input logic [7:0] op, input logic [15:0] a);
        emit(op); emit(a[7:0]); emit(a[15:8]);
    endtask

    task automatic patch(input int at, input int tgt);
        mem[at[11:0]]       = tgt[7:0];
        mem[at[11:0] + 1]   = tgt[15:8];
    endtask

    task automatic expect_wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        exp_t e;
        e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic check(input bit ok, input string tag, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // monitor: compares every write against the scoreboard
    always @(negedge clk) begin
        if (mon_en && mem_wr) begin
            exp_t e;
            total++;
            if (mem_rd) begin
                bad++;
                $display("FAIL R12: rd=%b wr=%b expected rd=0 wr=1", mem_rd, mem_wr);
            end
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2: write addr=%h data=%h expected no write", mem_addr, mem_wdata);
            end else begin
                e = exp_q.pop_front();
                if (mem_addr != e.addr || mem_wdata != e.data) begin
                    bad++;
                    $display("FAIL %s: addr=%h data=%h expected addr=%h data=%h",
                             e.tag, mem_addr, mem_wdata, e.addr, e.data);
                end
            end
        end
        if (mon_en && mem_rd && mem_addr == halt_addr) halt_hits++;
    end

    task automatic run_prog(input string name);
        int cyc;
        @(negedge clk);
        rst = 1'b0;
        check(mem_rd === 1'b1 && mem_wr === 1'b0 && mem_addr === 16'h0000, "R1",
              $sformatf("%s start rd=%b wr=%b addr=%h expected rd=1 wr=0 addr=0000",
                        name, mem_rd, mem_wr, mem_addr));
        halt_hits = 0;
        mon_en = 1'b1;
        cyc = 0;
        while (halt_hits < 2 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        mon_en = 1'b0;
        check(cyc < 20000, "R9", $sformatf("%s watchdog cycles=%0d expected halt", name, cyc));
        check(exp_q.size() == 0, "R2",
              $sformatf("%s pending writes=%0d expected 0", name, exp_q.size()));
        exp_q.delete();
        rst = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int fix;
        int loop_at;
        int t;
        repeat (3) @(negedge clk);

        // ---------- program A: instruction coverage ----------
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        mem[12'h900] = 8'h5A;
        mem[12'h901] = 8'hC8;
        ap = 0;
        emit(8'h0B); emit3(8'h02, 16'h0800); expect_wr(16'h0800, 8'h00, "R6");
        emit3(8'h01, 16'h0900); emit3(8'h02, 16'h0801); expect_wr(16'h0801, 8'h5A, "R2");
        emit(8'h03); emit(8'h0B); emit(8'h04);
        emit3(8'h02, 16'h0802); expect_wr(16'h0802, 8'h5A, "R3");
        emit3(8'h01, 16'h0901); emit(8'h08);
        emit3(8'h02, 16'h0803); expect_wr(16'h0803, 8'h22, "R4");
        emit(8'h09); emit3(8'h02, 16'h0804); expect_wr(16'h0804, 8'hC8, "R4");
        emit(8'h0C); emit3(8'h02, 16'h0805); expect_wr(16'h0805, 8'h48, "R5");
        emit(8'h0D); emit(8'h0E);
        emit3(8'h02, 16'h0806); expect_wr(16'h0806, 8'h00, "R5");
        fix = ap + 1; emit3(8'h06, 16'h0000);
        emit3(8'h02, 16'h08FF);
        patch(fix, ap);
        emit(8'h0F); emit3(8'h02, 16'h0807); expect_wr(16'h0807, 8'hFF, "R5");
        emit(8'h0A); emit3(8'h07, 16'h0700);
        emit3(8'h02, 16'h0808); expect_wr(16'h0808, 8'h00, "R9");
        emit3(8'h01, 16'h0900); emit(8'h03); emit(8'h04); emit(8'h00);
        fix = ap + 1; emit3(8'h06, 16'h0000);
        emit3(8'h02, 16'h08FE);
        patch(fix, ap);
        emit3(8'h02, 16'h0809); expect_wr(16'h0809, 8'h5A, "R7");
        emit(8'h10); emit(8'hFF); emit(8'h0A);
        emit3(8'h02, 16'h080A); expect_wr(16'h080A, 8'h5B, "R10");
        emit3(8'h01, 16'h0901); emit(8'h0A);
        fix = ap + 1; emit3(8'h07, 16'h0000);
        emit3(8'h02, 16'h08FD);
        patch(fix, ap);
        emit3(8'h06, 16'h0700);
        emit3(8'h02, 16'h080B); expect_wr(16'h080B, 8'hC9, "R9");
        fix = ap + 1; emit3(8'h05, 16'h0000);
        emit3(8'h02, 16'h08FC);
        patch(fix, ap);
        halt_addr = 16'(ap); emit3(8'h05, 16'(ap)); // R8 self-jump
        run_prog("alu");

        // ---------- program B: sum 1..22 ----------
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        mem[12'hA00] = 8'd22;
        ap = 0;
        emit(8'h0B);
        emit3(8'h02, 16'h0A01); expect_wr(16'h0A01, 8'h00, "R11");
        emit3(8'h02, 16'h0A02); expect_wr(16'h0A02, 8'h00, "R11");
        loop_at = ap;
        emit3(8'h01, 16'h0A02); emit(8'h0A); emit3(8'h02, 16'h0A02);
        emit(8'h03); emit3(8'h01, 16'h0A01); emit(8'h08);
        emit3(8'h02, 16'h0A01); emit3(8'h01, 16'h0A00); emit(8'h09);
        emit3(8'h07, 16'(loop_at));
        halt_addr = 16'(ap); emit3(8'h05, 16'(ap));
        t = 0;
        for (int k = 1; k <= 22; k++) begin
            t += k;
            expect_wr(16'h0A02, 8'(k), "R11");
            expect_wr(16'h0A01, 8'(t), "R11");
        end
        run_prog("sum");
        check(mem[12'hA01] == 8'd253, "R11",
              $sformatf("final sum=%0d expected 253", mem[12'hA01]));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule